// File: doc/BRIEF.md
# Doorbell to Message-Write Translator

This block sits behind a host's doorbell aperture in a non-transparent bridge. Each write that lands in the aperture rings one doorbell. The doorbell number is the write offset shifted right by the log2 of a programmable slot size. The block keeps a per-doorbell table of outbound 64-bit message addresses and 32-bit data words, which the configuration logic loads. For each rung doorbell it emits one message write toward the peer host on a request/ready port.

Every doorbell has its own slot and its own table entry. A host that hands out one shared message address is handled by loading the same address into every entry. A host that hands out one address per vector is handled by loading distinct addresses. The datapath is the same in both cases.

Rung doorbells wait in a pending mask. When several are pending, the lowest index leaves first. The block translates only after a configure command has set the active doorbell count and the interrupt mode. Writes before that, and writes beyond the active count, are discarded and counted.

Top module: `dbMsiXlate`

## Requirements
- R1: After reset, msgReq, configured, msixMode and dropCount are all zero.
- R2: A one-cycle cfgCmdValid pulse has these effects in the next cycle. configured is 1. msixMode takes cfgCmdArg bit 16. The active count takes cfgCmdArg[15:0], clamped to NUM_DB (32).
- R3: The doorbell index is dbWrOffset shifted right by entryLog2. An entryLog2 below 2 is treated as 2, so the slot size is at least 4 bytes. Offset bits inside a slot are ignored.
- R4: A doorbell write made before the first configure command, or with an index at or above the active count, produces no message. It increments dropCount by one, and dropCount saturates at its maximum.
- R5: A table write with cfgWrEn stores cfgWrData into entry cfgIdx. cfgSel selects the field: 0 is address bits 31:0, 1 is address bits 63:32, 2 is the data word. A message for index i carries that entry's 64-bit address and data word. Any number of entries may hold the same address.
- R6: While msgReq is high and msgReady is low, msgReq, msgAddr and msgData stay unchanged.
- R7: When more than one doorbell is pending at the moment a request is issued, the lowest index is issued first.
- R8: Ringing a doorbell that is already pending and not yet issued does not add a second message.
- R9: A pending doorbell is cleared when its message is accepted (msgReq and msgReady both high). With msgReady held high, a write at clock edge k makes msgReq high after edge k+1, and msgReq is low again after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Table write strobe |
| cfgSel | input | 2 | Table field select (0 addr low, 1 addr high, 2 data) |
| cfgIdx | input | 5 | Table entry index |
| cfgWrData | input | 32 | Table write data |
| cfgCmdValid | input | 1 | Configure-doorbell command strobe |
| cfgCmdArg | input | 32 | Command argument: [15:0] count, [16] mode |
| entryLog2 | input | 4 | log2 of the doorbell slot size in bytes |
| dbWrEn | input | 1 | Doorbell aperture write strobe |
| dbWrOffset | input | 16 | Byte offset of the write inside the aperture |
| msgReq | output | 1 | Message write request |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data word |
| msgReady | input | 1 | Message write accepted when high with msgReq |
| configured | output | 1 | Doorbell translation enabled |
| msixMode | output | 1 | Mode bit captured from the last command |
| dropCount | output | 16 | Saturating count of discarded doorbell writes |

## Verification
Two kinds of fault are visible at the ports within a few cycles of the write that exposes them. A corrupted pending mask shows up as a missing message, a duplicated message, or messages leaving in the wrong order. A wrong index computation delivers a message with another entry's address and data, or moves a write between the accepted and dropped cases, which dropCount shows on the next cycle. The bench rings doorbells while the output is held off, so that several are pending at once. This exposes both the ordering rule and the merging of repeated rings.

// File: rtl/dbmsi_pkg.sv
package dbmsi_pkg;
  localparam int DB_IDX_W = 5;

  typedef struct packed {
    logic                load;
    logic [DB_IDX_W-1:0] idx;
  } pathStrobe_t;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2
  } tabSel_e;
endpackage

// File: rtl/dbMsiCtrl.sv
module dbMsiCtrl
  import dbmsi_pkg::*;
#(
  parameter int NUM_DB = 32,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCmdValid,
  input  logic [31:0]      cfgCmdArg,
  input  logic [3:0]       entryLog2,
  input  logic             dbWrEn,
  input  logic [OFF_W-1:0] dbWrOffset,
  input  logic             msgReady,
  output logic             msgReq,
  output logic             configured,
  output logic             msixMode,
  output logic [CNT_W-1:0] dropCount,
  output pathStrobe_t      strobe
);
  localparam int IDX_W = $clog2(NUM_DB);
  localparam int NUM_W = $clog2(NUM_DB + 1);

  logic [NUM_W-1:0]  dbCount;
  logic [NUM_DB-1:0] pending, setMask, clrMask;
  logic [IDX_W-1:0]  curIdx, pickIdx;
  logic [3:0]        effShift;
  logic [OFF_W-1:0]  slotIdx;
  logic              hit, accept, load, pickFound;

  // slot index from the write offset; a slot is never smaller than 4 bytes
  always_comb begin
    effShift = (entryLog2 < 4'd2) ? 4'd2 : entryLog2;
    slotIdx  = dbWrOffset >> effShift;
    hit      = configured && (slotIdx < OFF_W'(dbCount));
    setMask  = (dbWrEn && hit) ? (NUM_DB'(1) << slotIdx[IDX_W-1:0]) : '0;
  end

  // lowest pending index wins
  always_comb begin
    pickIdx   = '0;
    pickFound = 1'b0;
    for (int i = 0; i < NUM_DB; i++) begin
      if (pending[i] && !pickFound) begin
        pickIdx   = IDX_W'(i);
        pickFound = 1'b1;
      end
    end
  end

  always_comb begin
    accept  = msgReq && msgReady;
    load    = !msgReq && pickFound;
    clrMask = accept ? (NUM_DB'(1) << curIdx) : '0;
  end

  assign strobe.load = load;
  assign strobe.idx  = DB_IDX_W'(pickIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      configured <= 1'b0;
      msixMode   <= 1'b0;
      dbCount    <= '0;
    end else if (cfgCmdValid) begin
      configured <= 1'b1;
      msixMode   <= cfgCmdArg[16];
      dbCount    <= (cfgCmdArg[15:0] > 16'(NUM_DB)) ? NUM_W'(NUM_DB)
                                                    : NUM_W'(cfgCmdArg[15:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      msgReq  <= 1'b0;
      curIdx  <= '0;
    end else begin
      pending <= (pending & ~clrMask) | setMask;
      if (load) begin
        msgReq <= 1'b1;
        curIdx <= pickIdx;
      end else if (accept) begin
        msgReq <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropCount <= '0;
    end else if (dbWrEn && !hit && (dropCount != {CNT_W{1'b1}})) begin
      dropCount <= dropCount + 1'b1;
    end
  end

  AST_NO_PEND_UNCONFIG: assert property (@(posedge clk) disable iff (!rstN)
    !configured |-> (pending == '0)); // R4
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dbWrEn && !hit && dropCount != {CNT_W{1'b1}}) |=> dropCount == $past(dropCount) + 1'b1); // R4
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    load |-> ((pending & ((NUM_DB'(1) << pickIdx) - NUM_DB'(1))) == '0)); // R7
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !(setMask[curIdx])) |=> !pending[$past(curIdx)]); // R9
  AST_CFG_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    cfgCmdValid |=> configured && (msixMode == $past(cfgCmdArg[16]))); // R2
endmodule

// File: rtl/dbMsiPath.sv
module dbMsiPath
  import dbmsi_pkg::*;
#(
  parameter int NUM_DB = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgSel,
  input  logic [DB_IDX_W-1:0] cfgIdx,
  input  logic [31:0]         cfgWrData,
  input  pathStrobe_t         strobe,
  input  logic                msgReq,
  input  logic                msgReady,
  output logic [63:0]         msgAddr,
  output logic [31:0]         msgData
);
  logic [31:0] addrLoTab [NUM_DB];
  logic [31:0] addrHiTab [NUM_DB];
  logic [31:0] dataTab   [NUM_DB];

  for (genvar g = 0; g < NUM_DB; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrLoTab[g] <= '0;
        addrHiTab[g] <= '0;
        dataTab[g]   <= '0;
      end else if (cfgWrEn && (cfgIdx == DB_IDX_W'(g))) begin
        case (tabSel_e'(cfgSel))
          SEL_ADDR_LO: addrLoTab[g] <= cfgWrData;
          SEL_ADDR_HI: addrHiTab[g] <= cfgWrData;
          SEL_DATA:    dataTab[g]   <= cfgWrData;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddr <= '0;
      msgData <= '0;
    end else if (strobe.load) begin
      msgAddr <= {addrHiTab[strobe.idx], addrLoTab[strobe.idx]};
      msgData <= dataTab[strobe.idx];
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (msgReq && !msgReady) |=> (msgReq && $stable(msgAddr) && $stable(msgData))); // R6
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    msgReq |-> !strobe.load); // R6
endmodule

// File: rtl/dbMsiXlate.sv
module dbMsiXlate
  import dbmsi_pkg::*;
#(
  parameter int NUM_DB = 32,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgSel,
  input  logic [DB_IDX_W-1:0] cfgIdx,
  input  logic [31:0]         cfgWrData,
  input  logic                cfgCmdValid,
  input  logic [31:0]         cfgCmdArg,
  input  logic [3:0]          entryLog2,
  input  logic                dbWrEn,
  input  logic [OFF_W-1:0]    dbWrOffset,
  output logic                msgReq,
  output logic [63:0]         msgAddr,
  output logic [31:0]         msgData,
  input  logic                msgReady,
  output logic                configured,
  output logic                msixMode,
  output logic [CNT_W-1:0]    dropCount
);
  pathStrobe_t strobe;

  dbMsiCtrl #(.NUM_DB(NUM_DB), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgCmdValid(cfgCmdValid), .cfgCmdArg(cfgCmdArg),
    .entryLog2(entryLog2), .dbWrEn(dbWrEn), .dbWrOffset(dbWrOffset),
    .msgReady(msgReady), .msgReq(msgReq), .configured(configured),
    .msixMode(msixMode), .dropCount(dropCount), .strobe(strobe)
  );

  dbMsiPath #(.NUM_DB(NUM_DB)) u_path (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgIdx(cfgIdx), .cfgWrData(cfgWrData), .strobe(strobe),
    .msgReq(msgReq), .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
  );
endmodule

// File: tb/dbMsiXlate_bench.sv
module dbMsiXlate_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn, cfgCmdValid, dbWrEn, msgReady;
  logic [1:0]  cfgSel;
  logic [4:0]  cfgIdx;
  logic [31:0] cfgWrData, cfgCmdArg;
  logic [3:0]  entryLog2;
  logic [15:0] dbWrOffset;
  logic        msgReq, configured, msixMode;
  logic [63:0] msgAddr;
  logic [31:0] msgData;
  logic [15:0] dropCount;

  int checks = 0;
  int errors = 0;
  int expDrop = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbMsiXlate u_dbMsiXlate (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgWrData(cfgWrData), .cfgCmdValid(cfgCmdValid), .cfgCmdArg(cfgCmdArg),
    .entryLog2(entryLog2), .dbWrEn(dbWrEn), .dbWrOffset(dbWrOffset),
    .msgReq(msgReq), .msgAddr(msgAddr), .msgData(msgData), .msgReady(msgReady),
    .configured(configured), .msixMode(msixMode), .dropCount(dropCount)
  );

  // vectors: offset, expected index, accepted (entry size 8 bytes, count 8)
  localparam int NV = 6;
  localparam logic [15:0] V_OFF [NV] = '{16'h0000, 16'h000C, 16'h0038, 16'h0021, 16'h0040, 16'h1000};
  localparam int          V_IDX [NV] = '{0, 1, 7, 4, 0, 0};
  localparam bit          V_ACC [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  function automatic logic [63:0] addrOf(int i);
    logic [31:0] lo;
    lo = (i % 2 == 0) ? 32'hFEE0_0000 : 32'hFEE0_0000 + 32'(i * 16);
    return {(i >= 16) ? 32'h1 : 32'h0, lo};
  endfunction

  function automatic logic [31:0] dataOf(int i);
    return 32'hA500 + 32'(i);
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ring(logic [15:0] off);
    dbWrEn = 1'b1; dbWrOffset = off;
    @(negedge clk);
    dbWrEn = 1'b0;
  endtask

  task automatic configure(logic [31:0] arg);
    cfgCmdValid = 1'b1; cfgCmdArg = arg;
    @(negedge clk);
    cfgCmdValid = 1'b0;
  endtask

  task automatic expectMsg(int idx, string req);
    for (int n = 0; n < 8; n++) begin
      if (msgReq) break;
      @(negedge clk);
    end
    check(msgReq == 1'b1, req, "msgReq", 64'(msgReq), 64'd1);
    check(msgAddr == addrOf(idx), req, "msgAddr", msgAddr, addrOf(idx));
    check(msgData == dataOf(idx), req, "msgData", 64'(msgData), 64'(dataOf(idx)));
    @(negedge clk);
  endtask

  task automatic expectNone(string req);
    int seen = 0;
    for (int n = 0; n < 4; n++) begin
      if (msgReq) seen++;
      @(negedge clk);
    end
    check(seen == 0, req, "unexpected message cycles", 64'(seen), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 0; cfgSel = 0; cfgIdx = 0; cfgWrData = 0;
    cfgCmdValid = 0; cfgCmdArg = 0; entryLog2 = 4'd3; dbWrEn = 0;
    dbWrOffset = 0; msgReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(msgReq == 0, "R1", "msgReq", 64'(msgReq), 0);
    check(configured == 0, "R1", "configured", 64'(configured), 0);
    check(msixMode == 0, "R1", "msixMode", 64'(msixMode), 0);
    check(dropCount == 0, "R1", "dropCount", 64'(dropCount), 0);

    // R5 load the table
    for (int i = 0; i < 32; i++) begin
      for (int s = 0; s < 3; s++) begin
        cfgWrEn = 1'b1; cfgIdx = 5'(i); cfgSel = 2'(s);
        cfgWrData = (s == 0) ? addrOf(i)[31:0] : (s == 1) ? addrOf(i)[63:32] : dataOf(i);
        @(negedge clk);
      end
    end
    cfgWrEn = 1'b0;

    // R4 ring before configuration
    ring(16'h0000);
    expDrop++;
    check(dropCount == 16'(expDrop), "R4", "dropCount unconfigured", 64'(dropCount), 64'(expDrop));
    expectNone("R4");

    // R2 configure: count 8, mode bit set
    configure({15'd0, 1'b1, 16'd8});
    check(configured == 1, "R2", "configured", 64'(configured), 1);
    check(msixMode == 1, "R2", "msixMode", 64'(msixMode), 1);

    // vector walk: R3 index, R4 drops, R5 payload, R9 single message
    for (int v = 0; v < NV; v++) begin
      ring(V_OFF[v]);
      if (V_ACC[v]) begin
        expectMsg(V_IDX[v], "R3/R5");
        expectNone("R9");
      end else begin
        expDrop++;
        check(dropCount == 16'(expDrop), "R4", "dropCount out of range", 64'(dropCount), 64'(expDrop));
        expectNone("R4");
      end
    end

    // R9 timing: msgReq high one edge after the write edge, low the next
    dbWrEn = 1'b1; dbWrOffset = 16'h0010;
    @(negedge clk);
    dbWrEn = 1'b0;
    check(msgReq == 0, "R9", "msgReq before issue", 64'(msgReq), 0);
    @(negedge clk);
    check(msgReq == 1, "R9", "msgReq issue cycle", 64'(msgReq), 1);
    @(negedge clk);
    check(msgReq == 0, "R9", "msgReq after accept", 64'(msgReq), 0);

    // R6 hold, R7 order, R8 merge
    msgReady = 1'b0;
    ring(16'h0028);             // index 5 issued first
    @(negedge clk);
    ring(16'h0030);             // 6
    ring(16'h0020);             // 4
    ring(16'h0008);             // 1
    ring(16'h0024);             // 4 again, merges
    check(msgReq == 1, "R6", "msgReq held", 64'(msgReq), 1);
    check(msgAddr == addrOf(5), "R6", "msgAddr held", msgAddr, addrOf(5));
    check(msgData == dataOf(5), "R6", "msgData held", 64'(msgData), 64'(dataOf(5)));
    msgReady = 1'b1;
    expectMsg(5, "R6");
    expectMsg(1, "R7");
    expectMsg(4, "R7");
    expectMsg(6, "R7");
    expectNone("R8");

    // R2 clamp and mode clear, R3 minimum slot size
    entryLog2 = 4'd2;
    configure({16'd0, 16'd40});
    check(msixMode == 0, "R2", "msixMode cleared", 64'(msixMode), 0);
    ring(16'd124);
    expectMsg(31, "R2");
    ring(16'd128);
    expDrop++;
    check(dropCount == 16'(expDrop), "R2", "index 32 dropped", 64'(dropCount), 64'(expDrop));
    expectNone("R2");
    entryLog2 = 4'd0;
    ring(16'd4);
    expectMsg(1, "R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule